// File: doc/BRIEF.md
# Coherent-Snapshot 64-bit Tick Counter

This block keeps a 64-bit up-counter that advances by one on every clock cycle in which the oscillator tick input is high. The counter never stops. It is reset to a parameter value, which is zero by default. Because a 32-bit bus cannot read 64 bits in one access, the live value is never shown on the bus directly.

To read the counter, software first writes a control word with the snapshot request bit set. The hardware keeps that bit set while a fixed synchronisation wait elapses. It then copies the live count into a 64-bit holding register and clears the bit. Software polls the bit until it reads zero, then reads the lower and upper halves in any order. Both halves come from the same instant, so the read never tears, even when the low half wraps between the two accesses.

The bus is a simple single-cycle register port. Writes are taken at the clock edge. Read data is combinational from the address while the read strobe is high.

Top module: `snap_counter64`

## Requirements
- R1: After reset the control word, the lower half and the upper half all read 0. The live counter starts at the RESET_COUNT parameter (0 by default), so a snapshot taken before any tick returns RESET_COUNT.
- R2: The live counter adds one at each rising clock edge where tick_i is high, holds otherwise, and wraps modulo 2^64 with the carry crossing from bit 31 into bit 32.
- R3: A write to offset 0xA0 with bit 1 (value 0x02) set, made while no snapshot is pending, makes bit 1 of the control word read 1 for exactly LATCH_DELAY cycles after the write edge, then 0.
- R4: When bit 1 clears, the holding register contains the live count as it stood just before the clearing edge: the reset value plus every tick sampled at earlier edges.
- R5: Offset 0xA4 returns holding bits 31:0 and offset 0xA8 returns holding bits 63:32. Both keep their value while the live counter advances, until the next snapshot completes.
- R6: A snapshot request written while one is pending is ignored: bit 1 still clears at the time set by the first request, and only one snapshot is taken.
- R7: Writes that have bit 1 clear, and writes to 0xA4, 0xA8 or any other offset, change neither the control word nor the holding register.
- R8: The control word reads 0 in every bit except bit 1. A read of an unmapped offset returns 0, and bus_rdata_o is 0 while bus_rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | Oscillator tick; each high cycle adds one to the counter |
| bus_wr_i | input | 1 | Write strobe, taken at the rising edge |
| bus_rd_i | input | 1 | Read strobe, qualifies bus_rdata_o |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |

## Verification
The bench targets tearing first. A second instance starts eight counts below 2^64, so its snapshots fall across the wrap from the low half into the high half. A design that captured the halves separately, or lost the carry, would return a high half that is off by one.

The bench counts the cycles for which the request bit stays set, including when a second request arrives during the wait. A design that restarted the wait, or took a second snapshot, would clear the bit late or leave an extra snapshot behind.

The bench also rereads the halves after many further ticks and after writes to the read-only offsets. This catches holding registers that follow the live count or accept bus writes.

// File: rtl/snc_pkg.sv
package snc_pkg;
  localparam int unsigned BUS_AW   = 8;
  localparam int unsigned BUS_DW   = 32;
  localparam int unsigned CNT_W    = 2 * BUS_DW;
  localparam int unsigned REQ_BIT  = 1;

  localparam logic [BUS_AW-1:0] OFS_CTRL = 8'hA0;
  localparam logic [BUS_AW-1:0] OFS_LO   = 8'hA4;
  localparam logic [BUS_AW-1:0] OFS_HI   = 8'hA8;

  typedef enum logic [1:0] {
    RSEL_NONE,
    RSEL_CTRL,
    RSEL_LO,
    RSEL_HI
  } rd_sel_e;
endpackage

// File: rtl/snc_rst_sync.sv
module snc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/snc_counter.sv
module snc_counter #(
  parameter int unsigned      W         = 64,
  parameter logic [W-1:0]     RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = tick_i;

  always_comb begin
    cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RESET_VAL;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2: one step per tick, modulo 2^W
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> cnt_q == $past(cnt_q) + W'(1));
  // R2: holds without a tick
  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/snc_latch_ctrl.sv
module snc_latch_ctrl #(
  parameter int unsigned LATCH_DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic busy_o,
  output logic capture_o
);
  localparam int unsigned WAIT_W = (LATCH_DELAY < 2) ? 1 : $clog2(LATCH_DELAY);
  localparam logic [WAIT_W-1:0] WAIT_INIT = WAIT_W'(LATCH_DELAY - 1);

  logic              busy_q, busy_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              capture;

  assign capture = busy_q && (wait_q == '0);

  always_comb begin
    busy_d = busy_q;
    wait_d = wait_q;
    if (capture) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      wait_d = wait_q - WAIT_W'(1);
    end else if (req_i) begin
      busy_d = 1'b1;
      wait_d = WAIT_INIT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wait_q <= '0;
    end else begin
      busy_q <= busy_d;
      wait_q <= wait_d;
    end
  end

  assign busy_o    = busy_q;
  assign capture_o = capture;

  // Checker-side age counter for the busy window (R3)
  logic [31:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      age_q <= '0;
    else if (busy_q) age_q <= age_q + 32'd1;
    else             age_q <= '0;
  end

  // R3: busy never outlives the configured wait
  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> age_q < LATCH_DELAY);
  // R3: an idle request raises busy on the next cycle
  p_busy_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && req_i) |=> busy_q);
  // R6: a request during the wait neither reloads nor extends it
  p_req_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !capture && req_i) |=> busy_q && wait_q == $past(wait_q) - WAIT_W'(1));
endmodule

// File: rtl/snc_snapshot_regs.sv
module snc_snapshot_regs
  import snc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              busy_i,
  input  logic              rd_i,
  input  logic [BUS_AW-1:0] addr_i,
  output logic [BUS_DW-1:0] rdata_o
);
  logic [CNT_W-1:0]  snap_q;
  rd_sel_e           rsel;
  logic [BUS_DW-1:0] ctrl_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         snap_q <= '0;
    else if (capture_i) snap_q <= count_i;
  end

  always_comb begin
    ctrl_word          = '0;
    ctrl_word[REQ_BIT] = busy_i;
  end

  always_comb begin
    rsel = RSEL_NONE;
    if (rd_i) begin
      unique case (addr_i)
        OFS_CTRL: rsel = RSEL_CTRL;
        OFS_LO:   rsel = RSEL_LO;
        OFS_HI:   rsel = RSEL_HI;
        default:  rsel = RSEL_NONE;
      endcase
    end
  end

  always_comb begin
    unique case (rsel)
      RSEL_CTRL: rdata_o = ctrl_word;
      RSEL_LO:   rdata_o = snap_q[BUS_DW-1:0];
      RSEL_HI:   rdata_o = snap_q[CNT_W-1:BUS_DW];
      default:   rdata_o = '0;
    endcase
  end

  // R5: holding register frozen between captures
  p_snap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> $stable(snap_q));
  // R4: capture takes the live count of that cycle
  p_snap_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> snap_q == $past(count_i));
endmodule

// File: rtl/snap_counter64.sv
module snap_counter64
  import snc_pkg::*;
#(
  parameter int unsigned       LATCH_DELAY = 2,
  parameter logic [CNT_W-1:0]  RESET_COUNT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [BUS_DW-1:0] bus_wdata_i,
  output logic [BUS_DW-1:0] bus_rdata_o
);
  logic             core_rst_n;
  logic [CNT_W-1:0] live_cnt;
  logic             snap_req;
  logic             busy;
  logic             capture;

  snc_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (core_rst_n)
  );

  snc_counter #(.W(CNT_W), .RESET_VAL(RESET_COUNT)) u_cnt (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .tick_i (tick_i),
    .cnt_o  (live_cnt)
  );

  assign snap_req = bus_wr_i && (bus_addr_i == OFS_CTRL) && bus_wdata_i[REQ_BIT];

  snc_latch_ctrl #(.LATCH_DELAY(LATCH_DELAY)) u_latch (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .req_i     (snap_req),
    .busy_o    (busy),
    .capture_o (capture)
  );

  snc_snapshot_regs u_regs (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .capture_i (capture),
    .count_i   (live_cnt),
    .busy_i    (busy),
    .rd_i      (bus_rd_i),
    .addr_i    (bus_addr_i),
    .rdata_o   (bus_rdata_o)
  );

  // R8: control word exposes only the request bit
  p_ctrl_bits_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bus_rd_i && bus_addr_i == OFS_CTRL) |-> (bus_rdata_o & ~(BUS_DW'(1) << REQ_BIT)) == '0);
  // R8: idle read strobe drives zero
  p_rd_idle_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    !bus_rd_i |-> bus_rdata_o == '0);
  // R7: a write without the request bit never starts a snapshot
  p_no_req_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!busy && !(bus_wr_i && bus_wdata_i[REQ_BIT])) |=> !busy);
endmodule

// File: tb/snap_counter64_bench.sv
module snap_counter64_bench;
  localparam int unsigned DLY     = 2;
  localparam logic [63:0] WRAP_RV = 64'hFFFF_FFFF_FFFF_FFF8;
  localparam logic [7:0]  A_CTRL  = 8'hA0;
  localparam logic [7:0]  A_LO    = 8'hA4;
  localparam logic [7:0]  A_HI    = 8'hA8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;

  int checks = 0;
  int fails  = 0;
  int tick_mode = 0;
  int phase = 0;

  logic [63:0] exp_q[$];
  logic [63:0] m_cnt = '0;
  logic        m_busy = 1'b0;
  int          m_wait = 0;
  logic [63:0] last_exp = '0;

  always #2 clk = ~clk;

  snap_counter64 #(.LATCH_DELAY(DLY)) u_snap_counter64 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata0));

  snap_counter64 #(.LATCH_DELAY(DLY), .RESET_COUNT(WRAP_RV)) u_snap_counter64_wrap (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata1));

  // Tick driver
  always @(negedge clk) begin
    phase = phase + 1;
    case (tick_mode)
      1:       tick = 1'b1;
      2:       tick = (phase % 3 == 0);
      default: tick = 1'b0;
    endcase
  end

  // Reference model: pushes each expected snapshot (offset from reset value)
  always @(posedge clk) begin
    if (rst_n) begin
      if (m_busy) begin
        if (m_wait == 0) begin
          exp_q.push_back(m_cnt);
          m_busy = 1'b0;
        end else begin
          m_wait = m_wait - 1;
        end
      end else if (wr && addr == A_CTRL && wdata[1]) begin
        m_busy = 1'b1;
        m_wait = DLY - 1;
      end
      if (tick) m_cnt = m_cnt + 64'd1;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // All bus tasks start and end at a falling edge
  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d0, output logic [31:0] d1);
    rd = 1'b1; addr = a;
    #1;
    d0 = rdata0; d1 = rdata1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_halves(string req, logic [63:0] e);
    logic [31:0] a, b;
    logic [63:0] ew;
    ew = e + WRAP_RV;
    bus_rd(A_LO, a, b);
    chk(req, "lo", a, e[31:0]);
    chk(req, "wrap lo", b, ew[31:0]);
    bus_rd(A_HI, a, b);
    chk(req, "hi", a, e[63:32]);
    chk(req, "wrap hi", b, ew[63:32]);
  endtask

  // Driver + monitor: request, poll, then compare against the scoreboard
  task automatic do_snap(string req);
    logic [31:0] a, b;
    bit done = 0;
    bus_wr(A_CTRL, 32'h2);
    for (int i = 0; i < 16; i++) begin
      bus_rd(A_CTRL, a, b);
      if (!a[1]) begin done = 1; break; end
    end
    chk(req, "poll cleared", {31'd0, done}, 32'd1);
    if (exp_q.size() == 0) begin
      chk(req, "scoreboard entry", 32'd0, 32'd1);
    end else begin
      last_exp = exp_q.pop_front();
      check_halves(req, last_exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] a, b;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    bus_rd(A_CTRL, a, b);
    chk("R1", "ctrl", a, 32'd0);
    bus_rd(A_LO, a, b);
    chk("R1", "lo", a, 32'd0);
    chk("R1", "wrap lo", b, 32'd0);
    bus_rd(A_HI, a, b);
    chk("R1", "hi", a, 32'd0);
    chk("R1", "wrap hi", b, 32'd0);

    // R1 R4: snapshot before any tick
    do_snap("R1");

    // R2 R4: continuous ticks, wrap instance crosses 2^64
    tick_mode = 1;
    idle(3);
    do_snap("R2");
    idle(5);
    do_snap("R2");

    // R5: halves hold while counter runs
    idle(50);
    check_halves("R5", last_exp);

    // R4: sparse ticks
    tick_mode = 2;
    idle(7);
    do_snap("R4");

    // R3: busy window length
    bus_wr(A_CTRL, 32'h2);
    for (int i = 0; i < DLY; i++) begin
      bus_rd(A_CTRL, a, b);
      chk("R3", "busy during wait", a, 32'h2);
    end
    bus_rd(A_CTRL, a, b);
    chk("R3", "busy cleared", a, 32'h0);
    last_exp = exp_q.pop_front();
    check_halves("R4", last_exp);

    // R6: second request while pending is ignored
    bus_wr(A_CTRL, 32'h2);
    bus_wr(A_CTRL, 32'hFFFF_FFFF);
    for (int i = 0; i < DLY - 1; i++) begin
      bus_rd(A_CTRL, a, b);
      chk("R6", "still pending", a, 32'h2);
    end
    bus_rd(A_CTRL, a, b);
    chk("R6", "cleared on first schedule", a, 32'h0);
    chk("R6", "single snapshot", exp_q.size(), 32'd1);
    last_exp = exp_q.pop_front();
    check_halves("R6", last_exp);

    // R7: writes without request bit and to data offsets
    bus_wr(A_CTRL, 32'h1);
    bus_rd(A_CTRL, a, b);
    chk("R7", "ctrl after 0x1", a, 32'h0);
    bus_wr(A_LO, 32'hDEAD_BEEF);
    bus_wr(A_HI, 32'h1234_5678);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    idle(3);
    bus_rd(A_CTRL, a, b);
    chk("R7", "ctrl after stray writes", a, 32'h0);
    check_halves("R7", last_exp);
    chk("R7", "no extra snapshot", exp_q.size(), 32'd0);

    // R8: unmapped offset and idle strobe
    bus_rd(8'h10, a, b);
    chk("R8", "unmapped", a, 32'h0);
    addr = A_LO;
    #1;
    chk("R8", "strobe low", rdata0, 32'h0);

    // R2: one more snapshot after a long run
    tick_mode = 1;
    idle(200);
    do_snap("R2");

    summary();
  end
endmodule